// File: doc/BRIEF.md
# Maskable interrupt flag controller

This block gathers event pulses from two groups of sixteen sources into two sticky 16-bit flag registers. Each flag register is paired bit for bit with a 16-bit mask register. A flag bit latches whenever its event strobe is high, whatever the mask says. The interrupt line toward the host rises only when a flag bit and its mask bit are both 1 and the global enable is 1.

The host reaches the four registers through a small port with an address, a read strobe, a write strobe and write data. Read data is combinational. When the host reads a flag register, that register clears on the same clock edge that ends the read. The interrupt line then falls one cycle later. The masks can be read and written. The flag registers cannot be written.

Top module: `maskable_irq_flags`

## Requirements
- R1: After reset, both flag registers and both mask registers read 0, and `irq` is 0.
- R2: A 1 on an event strobe bit in a cycle sets the matching flag bit at the next clock edge, even when the matching mask bit is 0.
- R3: A set flag bit stays at 1 over any number of cycles until the host reads its register.
- R4: `irq` is registered: it is 1 in the cycle after a cycle in which `glb_en` is 1 and some flag bit and its mask bit are both 1, and it is 0 otherwise.
- R5: While `glb_en` is 0, `irq` is 0 from the next cycle on, whatever the flags and masks hold.
- R6: Byte offset 0x0 holds flag register 1 and 0x2 holds flag register 2. A read returns the current value and clears only the register that was read, at the edge that ends the read.
- R7: If an event bit arrives in the same cycle as a clearing read of its register, the bit is set after that edge.
- R8: Offset 0x4 holds mask 1 and 0x6 holds mask 2. Both are written with `host_wdata`, and both read back exactly what was written. A mask bit of 1 enables its flag bit.
- R9: Writes to the flag offsets 0x0 and 0x2 leave the flag registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt1 | input | 16 | Event strobes for flag register 1 |
| evt2 | input | 16 | Event strobes for flag register 2 |
| glb_en | input | 1 | Global interrupt enable |
| host_addr | input | 3 | Register byte offset |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the offset in `host_addr` |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that a read strobe is held for exactly one cycle, with a stable address during that cycle. They also assume that event strobes are sampled only on clock edges. The bench always drives strobes and addresses on the falling edge and drops them on the next falling edge, so every read covers exactly one rising edge. The bench raises read and write together only when a test says so.

// File: rtl/maskable_irq_flags.sv
module maskable_irq_flags #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter logic [AW-1:0] OFS_FLAG1 = 3'h0,
  parameter logic [AW-1:0] OFS_FLAG2 = 3'h2,
  parameter logic [AW-1:0] OFS_MASK1 = 3'h4,
  parameter logic [AW-1:0] OFS_MASK2 = 3'h6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt1,
  input  logic [DW-1:0] evt2,
  input  logic          glb_en,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq
);

  logic [DW-1:0] flag1_q, flag2_q, mask1_q, mask2_q;
  logic          irq_q;

  wire sel_f1 = (host_addr == OFS_FLAG1);
  wire sel_f2 = (host_addr == OFS_FLAG2);
  wire sel_m1 = (host_addr == OFS_MASK1);
  wire sel_m2 = (host_addr == OFS_MASK2);

  wire clr1 = host_rd & sel_f1;
  wire clr2 = host_rd & sel_f2;

  wire pend = |(flag1_q & mask1_q) | |(flag2_q & mask2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag1_q <= '0;
      flag2_q <= '0;
      mask1_q <= '0;
      mask2_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flag1_q <= (clr1 ? '0 : flag1_q) | evt1;
      flag2_q <= (clr2 ? '0 : flag2_q) | evt2;
      if (host_wr && sel_m1) mask1_q <= host_wdata;
      if (host_wr && sel_m2) mask2_q <= host_wdata;
      irq_q <= glb_en & pend;
    end
  end

  assign host_rdata = sel_f1 ? flag1_q :
                      sel_f2 ? flag2_q :
                      sel_m1 ? mask1_q :
                      sel_m2 ? mask2_q : '0;
  assign irq = irq_q;

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt1) |=> ((flag1_q & $past(evt1)) == $past(evt1)));

  // R5
  gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq);

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel_f2 && evt2 == '0) |=> (flag2_q == '0));

  // R9
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && sel_f1 && evt1 == '0) |=> $stable(flag1_q));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(glb_en));

endmodule

// File: tb/test_maskable_irq_flags.sv
`timescale 1ns/1ps
module test_maskable_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt1 = '0, evt2 = '0, host_wdata = '0;
  logic        glb_en = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_rdata;
  logic        irq;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  maskable_irq_flags i_maskable_irq_flags (
    .clk(clk), .rst_n(rst_n), .evt1(evt1), .evt2(evt2), .glb_en(glb_en),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq));

  // columns: evt1, evt2, mask1, mask2, glb_en
  localparam logic [64:0] VEC [6] = '{
    {16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b1},
    {16'h0001, 16'h0000, 16'h0000, 16'hFFFF, 1'b1},
    {16'h0000, 16'h8000, 16'h0000, 16'h8000, 1'b1},
    {16'hA5A5, 16'h5A5A, 16'hFFFF, 16'hFFFF, 1'b0},
    {16'h0F00, 16'h00F0, 16'h00F0, 16'h0F00, 1'b1},
    {16'h1234, 16'h0000, 16'h0230, 16'h0000, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); evt1 = a; evt2 = b;
    @(negedge clk); evt1 = '0; evt2 = '0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd(3'h0, d); check("R1 flag1", d, 16'h0);
    rd(3'h2, d); check("R1 flag2", d, 16'h0);
    rd(3'h4, d); check("R1 mask1", d, 16'h0);
    rd(3'h6, d); check("R1 mask2", d, 16'h0);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] a, b, m1, m2;
      logic        g, e;
      {a, b, m1, m2, g} = VEC[i];
      e = g & (|(a & m1) | |(b & m2));
      glb_en = g;
      wr(3'h4, m1); wr(3'h6, m2);
      pulse(a, b);
      @(negedge clk);
      check("R4 vector irq", {15'b0, irq}, {15'b0, e});
      rd(3'h0, d); check("R2 vector flag1", d, a);
      rd(3'h2, d); check("R2 vector flag2", d, b);
      @(negedge clk);
      check("R6 irq after clear", {15'b0, irq}, 16'h0);
    end

    wr(3'h4, 16'hC3A5); wr(3'h6, 16'h7E81);
    rd(3'h4, d); check("R8 mask1 readback", d, 16'hC3A5);
    rd(3'h6, d); check("R8 mask2 readback", d, 16'h7E81);

    wr(3'h4, 16'h0000); wr(3'h6, 16'h0000);
    glb_en = 1'b1;
    pulse(16'h0010, 16'h0000);
    @(negedge clk);
    check("R2 masked no irq", {15'b0, irq}, 16'h0);
    repeat (5) @(negedge clk);
    rd(3'h0, d); check("R3 sticky flag", d, 16'h0010);

    wr(3'h0, 16'hFFFF); wr(3'h2, 16'hFFFF);
    rd(3'h0, d); check("R9 flag1 write ignored", d, 16'h0);
    rd(3'h2, d); check("R9 flag2 write ignored", d, 16'h0);

    wr(3'h4, 16'h0004);
    @(negedge clk); evt1 = 16'h0004;
    @(negedge clk); evt1 = '0;
    check("R4 latency irq still low", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R4 irq rises", {15'b0, irq}, 16'h1);
    glb_en = 1'b0;
    @(negedge clk);
    check("R5 enable off", {15'b0, irq}, 16'h0);
    glb_en = 1'b1;
    @(negedge clk);
    check("R5 enable back", {15'b0, irq}, 16'h1);

    @(negedge clk); host_addr = 3'h0; host_rd = 1'b1; evt1 = 16'h0002;
    #1 check("R7 read returns old", host_rdata, 16'h0004);
    @(negedge clk); host_rd = 1'b0; evt1 = '0;
    rd(3'h0, d); check("R7 new event kept", d, 16'h0002);

    pulse(16'h0100, 16'h0200);
    rd(3'h0, d); check("R6 flag1 cleared value", d, 16'h0100);
    rd(3'h2, d); check("R6 flag2 untouched", d, 16'h0200);
    rd(3'h2, d); check("R6 flag2 now clear", d, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule